// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tags and valid bits of a set-associative cache, without the data. Each accepted request carries one byte address. The block picks the set from the address bits just above the block offset and compares the tag against every way of that set. One clock later it returns a hit flag and a way index. On a hit, the way index points to the matching entry. On a miss, it points to the way that now holds the new tag.

A miss always fills an empty way first, and it takes the lowest-numbered empty way. Only when the set is full does the replacement input choose the way to replace. There are three choices: a pseudo-random pick, least recently used, or oldest fill. Two running counters report how many lookups were accepted and how many of them missed.

A reset or a flush sweeps the directory one set per clock, and lookups are held off while the sweep runs. A lookup in the cycle right after a miss to the same set already sees that fill.

Top module: `cache_tag_dir`

## Requirements
- R1: With the default geometry (16-byte blocks, 8 sets, 4 ways), bits [6:4] of the address select the set. The stored tag is the whole address with bits [6:0] cleared. Addresses that differ only in bits [3:0] hit the same entry. Addresses with the same bits [6:4] but different upper bits are separate entries.
- R2: A lookup hits when some valid way of its set holds an equal tag. The response then shows `rsp_hit_o`=1 and that way on `rsp_way_o`.
- R3: A miss in a set with at least one empty way fills the lowest-numbered empty way, whatever the replacement choice.
- R4: After a miss, the reported way holds the new tag and is valid. A lookup of the same block accepted in the very next cycle hits that way.
- R5: With `policy_i` = 1 or 3, a miss in a full set replaces the way whose last hit or fill lies furthest back.
- R6: With `policy_i` = 2, a miss in a full set replaces the way filled earliest. Hits do not change this order.
- R7: With `policy_i` = 0, a miss in a full set replaces a pseudo-randomly chosen way in 0..WAYS-1. Repeated conflict misses do not always pick the same way.
- R8: `rsp_valid_o` is high for exactly the one cycle after each accepted request, and low otherwise.
- R9: `access_cnt_o` rises by one for every accepted request, and `miss_cnt_o` rises by one for every miss. Reset clears both counters; a flush leaves them unchanged.
- R10: After reset is released, and after a flush is sampled, `req_ready_o` stays low for exactly SETS cycles. Afterwards every entry is empty.
- R11: While `flush_i` is high, `req_ready_o` is low in that same cycle and a request presented then is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Start an invalidation sweep |
| policy_i | input | 2 | Replacement choice: 0 random, 1 or 3 LRU, 2 FIFO |
| req_valid_i | input | 1 | Lookup request present |
| req_addr_i | input | ADDR_W | Byte address of the lookup |
| req_ready_o | output | 1 | Lookup can be accepted this cycle |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | log2(WAYS) | Way hit or filled |
| access_cnt_o | output | CNT_W | Accepted lookups since reset |
| miss_cnt_o | output | CNT_W | Misses since reset |

## Verification
The first lookups after a sweep fill one set in order. This separates empty-way preference from the replacement choice. The set is then stressed with a hit pattern that makes the least-recently-used way differ from the earliest-filled way, so the LRU and FIFO results cannot be mistaken for one another. Addresses that vary only in offset bits, only in upper bits, or only in set bits show whether the decode keeps the full upper address as tag. Runs of conflict misses under the random choice, back-to-back miss-then-hit pairs, and a flush raised together with a request cover fill forwarding and request refusal.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
    typedef enum logic [1:0] {
        REPL_RANDOM = 2'd0,
        REPL_LRU    = 2'd1,
        REPL_FIFO   = 2'd2,
        REPL_LRU2   = 2'd3
    } repl_e;
endpackage

// File: rtl/ctd_lfsr.sv
// Free-running Galois shift register; exposes its low OUT_W bits.
module ctd_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 2,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sr = (st_q.sr >> 1) ^ (st_q.sr[0] ? W'(TAPS) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sr <= W'(SEED);
        else        st_q <= st_d;
    end

    assign rnd_o = st_q.sr[OUT_W-1:0];

    // R7: the register must never lock up at zero
    p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);
endmodule

// File: rtl/ctd_age_rank.sv
// Per-set age ranking: rank WAYS-1 is newest, rank 0 is oldest.
// A touch promotes a way to newest and ages the ways that were newer than it.
module ctd_age_rank #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SET_W-1:0] clr_set_i,
    input  logic             touch_i,
    input  logic [SET_W-1:0] touch_set_i,
    input  logic [IDX_W-1:0] touch_way_i,
    input  logic [SET_W-1:0] look_set_i,
    output logic [IDX_W-1:0] oldest_o
);
    typedef logic [SETS-1:0][WAYS-1:0][IDX_W-1:0] rank_arr_t;
    typedef struct packed {
        rank_arr_t rank;
    } age_t;

    function automatic rank_arr_t start_ranks();
        rank_arr_t r;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                r[s][w] = IDX_W'(w);
        return r;
    endfunction

    localparam rank_arr_t RANK_INIT = start_ranks();

    age_t st_d, st_q;
    logic [IDX_W-1:0] old_rank;
    logic [WAYS-1:0]  zero_vec;

    always_comb begin
        st_d     = st_q;
        old_rank = st_q.rank[touch_set_i][touch_way_i];
        if (clr_i) begin
            for (int w = 0; w < WAYS; w++)
                st_d.rank[clr_set_i][w] = IDX_W'(w);
        end else if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (IDX_W'(w) == touch_way_i)
                    st_d.rank[touch_set_i][w] = IDX_W'(WAYS - 1);
                else if (st_q.rank[touch_set_i][w] > old_rank)
                    st_d.rank[touch_set_i][w] = st_q.rank[touch_set_i][w] - 1'b1;
            end
        end
    end

    always_comb begin
        oldest_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            zero_vec[w] = (st_q.rank[look_set_i][w] == '0);
            if (zero_vec[w]) oldest_o = IDX_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.rank <= RANK_INIT;
        else        st_q <= st_d;
    end

    // R5: ranks stay a permutation, so exactly one way is oldest
    p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_vec) == 1);

    // R5: a touched way becomes the newest
    p_touch_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_i && !clr_i) |=>
            st_q.rank[$past(touch_set_i)][$past(touch_way_i)] == IDX_W'(WAYS - 1));
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
    parameter int ADDR_W      = 32,
    parameter int BLK_BYTES   = 16,
    parameter int WAYS        = 4,
    parameter int CACHE_BYTES = 512,
    parameter int CNT_W       = 32,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [1:0]        policy_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [IDX_W-1:0]  rsp_way_o,
    output logic [CNT_W-1:0]  access_cnt_o,
    output logic [CNT_W-1:0]  miss_cnt_o
);
    import ctd_pkg::*;

    localparam int SETS  = CACHE_BYTES / (WAYS * BLK_BYTES);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'(SETS - 1) << OFF_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);
    localparam logic [ADDR_W-1:0] TAG_MASK = ~(SET_MASK | BLK_MASK);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tag;
        logic                                  sweep;
        logic [SET_W-1:0]                      sweep_idx;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic [IDX_W-1:0]                      rsp_way;
        logic [CNT_W-1:0]                      acc;
        logic [CNT_W-1:0]                      miss;
    } dir_t;

    dir_t st_d, st_q;

    logic              accept;
    logic [SET_W-1:0]  look_set;
    logic [ADDR_W-1:0] look_tag;
    logic [WAYS-1:0]   hit_vec, free_vec;
    logic              any_hit, any_free;
    logic [IDX_W-1:0]  hit_way, free_way, pol_way, fill_way, pick_way;
    logic [IDX_W-1:0]  rnd_way, lru_way, fifo_way;
    repl_e             policy;

    assign req_ready_o = !st_q.sweep && !flush_i;
    assign accept      = req_valid_i && req_ready_o;
    assign look_set    = SET_W'((req_addr_i & SET_MASK) >> OFF_W);
    assign look_tag    = req_addr_i & TAG_MASK;
    assign policy      = repl_e'(policy_i);

    // tag compare and empty-way search, lowest index wins
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit_vec[w]  = st_q.valid[look_set][w] && (st_q.tag[look_set][w] == look_tag);
            free_vec[w] = !st_q.valid[look_set][w];
            if (hit_vec[w])  hit_way  = IDX_W'(w);
            if (free_vec[w]) free_way = IDX_W'(w);
        end
        any_hit  = |hit_vec;
        any_free = |free_vec;
    end

    always_comb begin
        unique case (policy)
            REPL_RANDOM: pol_way = rnd_way;
            REPL_FIFO:   pol_way = fifo_way;
            default:     pol_way = lru_way;
        endcase
        fill_way = any_free ? free_way : pol_way;
        pick_way = any_hit ? hit_way : fill_way;
    end

    ctd_lfsr #(.W(16), .OUT_W(IDX_W)) i_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd_way)
    );

    // recency: touched on hits and on fills
    ctd_age_rank #(.SETS(SETS), .WAYS(WAYS)) i_recency (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (st_q.sweep),
        .clr_set_i   (st_q.sweep_idx),
        .touch_i     (accept),
        .touch_set_i (look_set),
        .touch_way_i (pick_way),
        .look_set_i  (look_set),
        .oldest_o    (lru_way)
    );

    // fill order: touched on fills only
    ctd_age_rank #(.SETS(SETS), .WAYS(WAYS)) i_fill_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (st_q.sweep),
        .clr_set_i   (st_q.sweep_idx),
        .touch_i     (accept && !any_hit),
        .touch_set_i (look_set),
        .touch_way_i (fill_way),
        .look_set_i  (look_set),
        .oldest_o    (fifo_way)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        if (flush_i) begin
            st_d.sweep     = 1'b1;
            st_d.sweep_idx = '0;
        end else if (st_q.sweep) begin
            st_d.valid[st_q.sweep_idx] = '0;
            st_d.sweep_idx = st_q.sweep_idx + 1'b1;
            if (st_q.sweep_idx == SET_W'(SETS - 1)) st_d.sweep = 1'b0;
        end else if (accept) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_hit   = any_hit;
            st_d.rsp_way   = pick_way;
            st_d.acc       = st_q.acc + 1'b1;
            if (!any_hit) begin
                st_d.miss                     = st_q.miss + 1'b1;
                st_d.valid[look_set][fill_way] = 1'b1;
                st_d.tag[look_set][fill_way]   = look_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sweep <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o  = st_q.rsp_valid;
    assign rsp_hit_o    = st_q.rsp_hit;
    assign rsp_way_o    = st_q.rsp_way;
    assign access_cnt_o = st_q.acc;
    assign miss_cnt_o   = st_q.miss;

    // R2: fills never duplicate a tag inside one set
    p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4: the filled way is valid one cycle later
    p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !any_hit) |=> st_q.valid[$past(look_set)][$past(fill_way)]);

    // R8: a response follows each accepted request, and nothing else
    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid_o);
    p_no_stray_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid_o);

    // R9: counters advance by one per accepted lookup
    p_acc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> access_cnt_o == $past(access_cnt_o) + 1'b1);
    p_miss_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt_o <= access_cnt_o);

    // R10: a sampled flush stalls the next cycle
    p_flush_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !req_ready_o);
endmodule

// File: tb/test_cache_tag_dir.sv
module test_cache_tag_dir;
    localparam int SETS = 8;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [1:0]  policy_i = 2'd1;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        req_ready_o, rsp_valid_o, rsp_hit_o;
    logic [1:0]  rsp_way_o;
    logic [31:0] access_cnt_o, miss_cnt_o;

    always #4 clk = ~clk;

    cache_tag_dir i_cache_tag_dir (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .policy_i(policy_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
        .rsp_hit_o(rsp_hit_o), .rsp_way_o(rsp_way_o),
        .access_cnt_o(access_cnt_o), .miss_cnt_o(miss_cnt_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference
    bit          mv[SETS][WAYS];
    logic [31:0] mt[SETS][WAYS];
    int          lru_st[SETS][WAYS], fifo_st[SETS][WAYS], gen[SETS];
    int          exp_acc = 0, exp_miss = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int hi, input int set, input int off);
        return (32'(hi) << 7) | (32'(set) << 4) | 32'(off);
    endfunction

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            gen[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0; lru_st[s][w] = 0; fifo_st[s][w] = 0;
            end
        end
    endtask

    task automatic lookup(input logic [31:0] addr, input int pol, input string req,
                          output int way_o);
        int set, exp_way, best;
        bit hit;
        logic [31:0] tag;
        set = int'((addr >> 4) & 7);
        tag = addr & ~32'h7F;
        hit = 0; exp_way = -1;
        for (int w = 0; w < WAYS; w++)
            if (mv[set][w] && mt[set][w] == tag) begin hit = 1; exp_way = w; end
        if (!hit) begin
            for (int w = WAYS - 1; w >= 0; w--) if (!mv[set][w]) exp_way = w;
            if (exp_way < 0 && pol != 0) begin
                best = 0;
                for (int w = 1; w < WAYS; w++) begin
                    if (pol == 2 && fifo_st[set][w] < fifo_st[set][best]) best = w;
                    if (pol != 2 && lru_st[set][w] < lru_st[set][best]) best = w;
                end
                exp_way = best;
            end
        end
        chk("R10 ready before lookup", req_ready_o, 1);
        policy_i = 2'(pol); req_addr_i = addr; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R8 response valid", rsp_valid_o, 1);
        chk({req, " hit flag"}, rsp_hit_o, hit);
        if (exp_way >= 0) chk({req, " way"}, rsp_way_o, exp_way);
        else begin
            chk("R7 random way in range", (int'(rsp_way_o) < WAYS), 1);
            exp_way = int'(rsp_way_o);
        end
        way_o = exp_way;
        exp_acc++;
        gen[set]++;
        lru_st[set][exp_way] = gen[set];
        if (!hit) begin
            exp_miss++;
            mv[set][exp_way] = 1; mt[set][exp_way] = tag;
            fifo_st[set][exp_way] = gen[set];
        end
        chk("R9 access count", access_cnt_o, exp_acc);
        chk("R9 miss count", miss_cnt_o, exp_miss);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R8 no response when idle", rsp_valid_o, 0);
        end
    endtask

    task automatic count_stall(input string req);
        int lows = 0;
        while (!req_ready_o && lows < 1000) begin lows++; @(negedge clk); end
        chk(req, lows, SETS);
    endtask

    task automatic do_flush(input bit with_req);
        int acc_before = int'(access_cnt_o);
        flush_i = 1'b1;
        if (with_req) begin req_valid_i = 1'b1; req_addr_i = mk(1, 2, 0); end
        #1;
        chk("R11 ready low with flush", req_ready_o, 0);
        @(negedge clk);
        flush_i = 1'b0; req_valid_i = 1'b0;
        if (with_req) begin
            chk("R11 request refused during flush", rsp_valid_o, 0);
            chk("R11 access count unchanged", access_cnt_o, acc_before);
        end
        count_stall("R10 flush stall length");
        model_clear();
        chk("R9 counters kept across flush", access_cnt_o, exp_acc);
    endtask

    int way;
    int seen;

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 access count after reset", access_cnt_o, 0);
        chk("R9 miss count after reset", miss_cnt_o, 0);
        chk("R8 no response after reset", rsp_valid_o, 0);
        count_stall("R10 reset stall length");

        // R3: fill set 2 in way order, LRU selected
        for (int t = 0; t < 4; t++) lookup(mk(t + 1, 2, 0), 1, "R3 empty-way fill", way);
        // R2: hits on ways 0 and 2
        lookup(mk(1, 2, 4), 1, "R2 hit", way);
        lookup(mk(3, 2, 8), 1, "R2 hit", way);
        // R5: conflict miss replaces way 1
        lookup(mk(9, 2, 0), 1, "R5 lru victim", way);
        chk("R5 lru picked way 1", way, 1);
        lookup(mk(2, 2, 0), 1, "R5 evicted block misses", way);
        // R4: miss then immediate hit
        lookup(mk(20, 2, 0), 1, "R4 miss", way);
        lookup(mk(20, 2, 12), 1, "R4 back-to-back hit", way);
        // R1: offset-only change hits; same tag in another set separate
        lookup(mk(20, 2, 15), 3, "R1 offset bits ignored", way);
        lookup(mk(20, 5, 0), 3, "R1 other set separate", way);
        lookup(mk(21, 5, 0), 3, "R1 upper bits distinct", way);
        idle(3);

        // R6: FIFO after a flush
        do_flush(0);
        for (int t = 0; t < 4; t++) lookup(mk(t + 30, 5, 0), 2, "R3 empty-way fill", way);
        for (int r = 0; r < 3; r++) lookup(mk(30, 5, 0), 2, "R2 hit", way);
        lookup(mk(40, 5, 0), 2, "R6 fifo victim", way);
        chk("R6 fifo picked way 0", way, 0);
        lookup(mk(41, 5, 0), 2, "R6 fifo victim", way);
        chk("R6 fifo picked way 1", way, 1);
        lookup(mk(30, 5, 0), 2, "R6 earliest block gone", way);
        idle(2);

        // R7: random victims, flush raised together with a request
        do_flush(1);
        for (int t = 0; t < 4; t++) lookup(mk(t + 50, 3, 0), 0, "R3 empty-way fill", way);
        seen = 0;
        for (int t = 0; t < 40; t++) begin
            lookup(mk(t + 100, 3, 0), 0, "R7 random miss", way);
            seen |= (1 << way);
        end
        chk("R7 more than one way chosen", ($countones(seen) >= 2), 1);
        lookup(mk(139, 3, 0), 0, "R4 last fill hits", way);
        idle(2);
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule